// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block sits beside one DMA channel and turns the channel's per-packet completion pulses into fewer interrupts. A countdown counter is loaded from a programmable threshold. Each completion takes one off it, and when it reaches zero a completion-interrupt flag is raised and the count starts over. A second mechanism is an inactivity delay timer. Every completion restarts it, and it counts down on a prescaled tick. If no further completion arrives before it runs out, it raises a delay-interrupt flag and also restarts the countdown. A third flag records channel errors.

The three pending flags are held in a small status register that software clears by writing ones. A level interrupt line is high while any pending flag has its enable set. A status read word reports the flags together with the live countdown and the remaining delay count.

The delay timer is a two-state machine. In `TMR_IDLE` the remaining count is zero. The transition `IDLE->RUN` happens on a completion while the delay setting is nonzero. In `TMR_RUN`, the transition `RUN->RUN (restart)` happens on a completion with a nonzero delay setting, and `RUN->RUN (tick)` happens on a prescaler tick while the count is above 1. The transition `RUN->IDLE (expire)` happens on a tick while the count is 1.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, the countdown reads 1, the delay count reads 0, all pending flags are 0 and `irq_o` is low.
- R2: Each `done_i` pulse lowers the countdown by one. A pulse that takes it from 1 to 0 instead sets the completion flag (status bit 12) and reloads the countdown from `ctrl_thr_i`.
- R3: A countdown of 0 behaves as 256: a completion moves it to 255 without raising the completion flag.
- R4: A cycle with `ctrl_wr_i` high loads the countdown from `ctrl_thr_i` of that cycle. A completion in the same cycle neither counts nor raises a flag.
- R5: A completion while `ctrl_dly_i` is nonzero restarts the delay count at `ctrl_dly_i`. When `ctrl_dly_i` is zero, a completion leaves the delay count untouched.
- R6: The delay count drops by one once per tick, and a tick comes every PRESCALE cycles. On its step from 1 to 0 it sets the delay flag (status bit 13) and reloads the countdown from `ctrl_thr_i`. It fires once and then stays at 0.
- R7: When a completion and a delay expiry fall in the same cycle, both flags are set. The countdown is reloaded once, with no extra decrement, and the delay count restarts.
- R8: An `err_i` pulse sets the error flag (status bit 14).
- R9: `irq_o` is high exactly when some pending flag (status bits 14:12) is set and its enable in `ctrl_ien_i` (bit 0 for completion, bit 1 for delay, bit 2 for error) is also set.
- R10: A cycle with `stat_wr_i` high clears each pending flag whose bit in `stat_clr_i` is 1 (bit 0 for status bit 12, bit 1 for 13, bit 2 for 14), and the other flags keep their values. A flag being set in that same cycle stays set.
- R11: `stat_rdata_o` carries the delay count in bits 31:24, the countdown in bits 23:16 and the flags in bits 14:12. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle completion strobe from the channel |
| err_i | input | 1 | One-cycle error strobe from the channel |
| ctrl_wr_i | input | 1 | High in the cycle the control word is written |
| ctrl_thr_i | input | 8 | Completion threshold field of the control word |
| ctrl_dly_i | input | 8 | Delay timer setting, 0 disables restarts |
| ctrl_ien_i | input | 3 | Interrupt enables {error, delay, completion} |
| stat_wr_i | input | 1 | Status write strobe |
| stat_clr_i | input | 3 | Write-one-to-clear mask {error, delay, completion} |
| stat_rdata_o | output | 32 | Status read word |
| irq_o | output | 1 | Level interrupt |

## Verification
The countdown is driven with a small threshold, with threshold zero and with a threshold rewritten in the middle of a run. These cases separate a plain modulo counter from one that reloads correctly and wraps from zero. The delay timer is started once and left to run out, which measures its latency against the tick period and shows that it fires only once. It is then lined up so that its expiry lands on a completion edge, which exposes any double reload. Clear writes with partial masks, and clears that collide with new events, show which flags the write can touch.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    localparam int FIELD_W  = 8;
    localparam int STAT_W   = 32;
    localparam int NFLAG    = 3;
    localparam int FLAG_LSB = 12;
    localparam int CNT_LSB  = 16;
    localparam int TMR_LSB  = 24;

    localparam int F_DONE = 0;
    localparam int F_DLY  = 1;
    localparam int F_ERR  = 2;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/irq_coal_prescaler.sv
module irq_coal_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick_o = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/irq_coal_delay_timer.sv
module irq_coal_delay_timer
    import irq_coal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic [FIELD_W-1:0] load_i,
    input  logic               tick_i,
    output logic [FIELD_W-1:0] value_o,
    output logic               expire_o
);
    tmr_state_e        state_q, state_d;
    logic [FIELD_W-1:0] val_q, val_d;
    logic               last_step;

    assign last_step = (val_q == FIELD_W'(1));

    always_comb begin
        state_d = state_q;
        val_d   = val_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (restart_i) begin
                    state_d = TMR_RUN;
                    val_d   = load_i;
                end
            end
            TMR_RUN: begin
                if (restart_i) begin
                    val_d = load_i;
                end else if (tick_i) begin
                    val_d = val_q - 1'b1;
                    if (last_step)
                        state_d = TMR_IDLE;
                end
            end
            default: begin
                state_d = TMR_IDLE;
                val_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
        end
    end

    always_comb begin
        value_o  = val_q;
        expire_o = (state_q == TMR_RUN) && tick_i && last_step;
    end
endmodule

// File: rtl/irq_coal_countdown.sv
module irq_coal_countdown
    import irq_coal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] thr_i,
    input  logic               dec_i,
    input  logic               reload_i,
    output logic [FIELD_W-1:0] value_o,
    output logic               hit_o
);
    logic [FIELD_W-1:0] cnt_q;

    assign hit_o = dec_i && !load_i && (cnt_q == FIELD_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= FIELD_W'(1);
        else if (load_i || hit_o || reload_i)
            cnt_q <= thr_i;
        else if (dec_i)
            cnt_q <= cnt_q - 1'b1;
    end

    assign value_o = cnt_q;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
    import irq_coal_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  logic               err_i,
    input  logic               ctrl_wr_i,
    input  logic [FIELD_W-1:0] ctrl_thr_i,
    input  logic [FIELD_W-1:0] ctrl_dly_i,
    input  logic [NFLAG-1:0]   ctrl_ien_i,
    input  logic               stat_wr_i,
    input  logic [NFLAG-1:0]   stat_clr_i,
    output logic [STAT_W-1:0]  stat_rdata_o,
    output logic               irq_o
);
    logic               tick;
    logic               expire;
    logic               hit;
    logic [FIELD_W-1:0] tmr_val;
    logic [FIELD_W-1:0] cnt_val;
    logic [NFLAG-1:0]   pend_q;
    logic [NFLAG-1:0]   set_vec;
    logic [NFLAG-1:0]   clr_vec;

    irq_coal_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    irq_coal_delay_timer u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (done_i && (ctrl_dly_i != '0)),
        .load_i    (ctrl_dly_i),
        .tick_i    (tick),
        .value_o   (tmr_val),
        .expire_o  (expire)
    );

    irq_coal_countdown u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ctrl_wr_i),
        .thr_i    (ctrl_thr_i),
        .dec_i    (done_i),
        .reload_i (expire),
        .value_o  (cnt_val),
        .hit_o    (hit)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[F_DONE] = hit;
        set_vec[F_DLY]  = expire;
        set_vec[F_ERR]  = err_i;
        clr_vec         = stat_wr_i ? stat_clr_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    always_comb begin
        stat_rdata_o = '0;
        stat_rdata_o[TMR_LSB +: FIELD_W]  = tmr_val;
        stat_rdata_o[CNT_LSB +: FIELD_W]  = cnt_val;
        stat_rdata_o[FLAG_LSB +: NFLAG]   = pend_q;
        irq_o = |(pend_q & ctrl_ien_i);
    end
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done_i,
    input logic        err_i,
    input logic        ctrl_wr_i,
    input logic [7:0]  ctrl_thr_i,
    input logic [7:0]  ctrl_dly_i,
    input logic [2:0]  ctrl_ien_i,
    input logic        stat_wr_i,
    input logic [2:0]  stat_clr_i,
    input logic [31:0] stat_rdata_o,
    input logic        irq_o
);
    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|stat_rdata_o[14:12]));

    // R4
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> stat_rdata_o[23:16] == $past(ctrl_thr_i));

    // R2
    count_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ctrl_wr_i && stat_rdata_o[23:16] == 8'd1) |=> stat_rdata_o[12]);

    // R5
    delay_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ctrl_dly_i != 8'd0) |=> stat_rdata_o[31:24] == $past(ctrl_dly_i));

    // R10
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && stat_clr_i[0] && !done_i) |=> !stat_rdata_o[12]);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> stat_rdata_o[14]);

    // R6
    delay_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> stat_rdata_o[31:24] <= $past(stat_rdata_o[31:24]));

    // R11
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata_o[11:0] == 12'd0 && stat_rdata_o[15] == 1'b0);
endmodule

bind irq_coalesce irq_coalesce_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_i       (done_i),
    .err_i        (err_i),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_thr_i   (ctrl_thr_i),
    .ctrl_dly_i   (ctrl_dly_i),
    .ctrl_ien_i   (ctrl_ien_i),
    .stat_wr_i    (stat_wr_i),
    .stat_clr_i   (stat_clr_i),
    .stat_rdata_o (stat_rdata_o),
    .irq_o        (irq_o)
);

// File: tb/irq_coalesce_tb.sv
`timescale 1ns/1ps
module irq_coalesce_tb;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic        err_i = 1'b0;
    logic        ctrl_wr_i = 1'b0;
    logic [7:0]  ctrl_thr_i = 8'd1;
    logic [7:0]  ctrl_dly_i = 8'd0;
    logic [2:0]  ctrl_ien_i = 3'd0;
    logic        stat_wr_i = 1'b0;
    logic [2:0]  stat_clr_i = 3'd0;
    logic [31:0] stat_rdata_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_coalesce #(.PRESCALE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .err_i(err_i),
        .ctrl_wr_i(ctrl_wr_i), .ctrl_thr_i(ctrl_thr_i), .ctrl_dly_i(ctrl_dly_i),
        .ctrl_ien_i(ctrl_ien_i), .stat_wr_i(stat_wr_i), .stat_clr_i(stat_clr_i),
        .stat_rdata_o(stat_rdata_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] f_tmr();
        return stat_rdata_o[31:24];
    endfunction
    function automatic logic [7:0] f_cnt();
        return stat_rdata_o[23:16];
    endfunction
    function automatic logic [2:0] f_flags();
        return stat_rdata_o[14:12];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] thr, input logic [7:0] dly, input logic [2:0] ien);
        ctrl_thr_i = thr;
        ctrl_dly_i = dly;
        ctrl_ien_i = ien;
        ctrl_wr_i  = 1'b1;
        @(negedge clk);
        ctrl_wr_i  = 1'b0;
    endtask

    task automatic pulse_done();
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        stat_wr_i  = 1'b1;
        stat_clr_i = m;
        @(negedge clk);
        stat_wr_i  = 1'b0;
        stat_clr_i = 3'd0;
    endtask

    task automatic t_reset();
        check("R1 reset status word", stat_rdata_o, 32'h0001_0000);
        check("R1 reset irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_count();
        write_ctrl(8'd3, 8'd0, 3'b000);
        check("R4 load threshold", {24'd0, f_cnt()}, 32'd3);
        pulse_done();
        pulse_done();
        check("R2 countdown after two", {24'd0, f_cnt()}, 32'd1);
        check("R2 no flag yet", {29'd0, f_flags()}, 32'd0);
        pulse_done();
        check("R2 completion flag", {29'd0, f_flags()}, 32'b001);
        check("R2 countdown reloaded", {24'd0, f_cnt()}, 32'd3);
        check("R9 irq masked", {31'd0, irq_o}, 32'd0);
        ctrl_ien_i = 3'b001;
        #1;
        check("R9 irq enabled", {31'd0, irq_o}, 32'd1);
        clear_flags(3'b110);
        check("R10 other flags kept", {29'd0, f_flags()}, 32'b001);
        clear_flags(3'b001);
        check("R10 flag cleared", {29'd0, f_flags()}, 32'd0);
        check("R9 irq drops", {31'd0, irq_o}, 32'd0);
        ctrl_ien_i = 3'b000;
    endtask

    task automatic t_zero_thr();
        write_ctrl(8'd0, 8'd0, 3'b000);
        pulse_done();
        check("R3 wrap to 255", {24'd0, f_cnt()}, 32'd255);
        check("R3 no flag on wrap", {29'd0, f_flags()}, 32'd0);
        for (int i = 0; i < 255; i++) pulse_done();
        check("R3 flag after 256", {29'd0, f_flags()}, 32'b001);
        check("R3 reload to 0", {24'd0, f_cnt()}, 32'd0);
        clear_flags(3'b111);
    endtask

    task automatic t_ctrl_override();
        write_ctrl(8'd5, 8'd0, 3'b000);
        pulse_done();
        pulse_done();
        check("R2 countdown 3", {24'd0, f_cnt()}, 32'd3);
        done_i = 1'b1;
        write_ctrl(8'd7, 8'd0, 3'b000);
        done_i = 1'b0;
        check("R4 write beats completion", {24'd0, f_cnt()}, 32'd7);
        write_ctrl(8'd1, 8'd0, 3'b000);
        done_i = 1'b1;
        write_ctrl(8'd1, 8'd0, 3'b000);
        done_i = 1'b0;
        check("R4 no flag with write", {29'd0, f_flags()}, 32'd0);
    endtask

    task automatic t_delay();
        int n;
        write_ctrl(8'd0, 8'd0, 3'b000);
        pulse_done();
        for (int i = 0; i < 10; i++) @(negedge clk);
        check("R5 delay zero keeps timer", {24'd0, f_tmr()}, 32'd0);
        write_ctrl(8'd10, 8'd3, 3'b010);
        pulse_done();
        check("R5 timer started", {24'd0, f_tmr()}, 32'd3);
        check("R11 countdown field", {24'd0, f_cnt()}, 32'd9);
        n = 0;
        while (!stat_rdata_o[13] && n < 100) begin
            @(negedge clk);
            n++;
        end
        total++;
        if (n < 2*P+1 || n > 3*P) begin
            bad++;
            $display("FAIL R6 expiry latency actual=%0d expected=%0d..%0d", n, 2*P+1, 3*P);
        end
        check("R6 countdown reloaded", {24'd0, f_cnt()}, 32'd10);
        check("R6 timer at zero", {24'd0, f_tmr()}, 32'd0);
        check("R9 delay irq", {31'd0, irq_o}, 32'd1);
        clear_flags(3'b010);
        for (int i = 0; i < 40; i++) @(negedge clk);
        check("R6 fires once", {29'd0, f_flags()}, 32'd0);
        ctrl_ien_i = 3'b000;
    endtask

    task automatic t_same_cycle();
        int n;
        write_ctrl(8'd2, 8'd2, 3'b000);
        pulse_done();
        check("R7 setup countdown", {24'd0, f_cnt()}, 32'd1);
        n = 0;
        while (f_tmr() != 8'd1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        for (int i = 0; i < P-1; i++) @(negedge clk);
        pulse_done();
        check("R7 both flags", {29'd0, f_flags()}, 32'b011);
        check("R7 single reload", {24'd0, f_cnt()}, 32'd2);
        check("R7 timer restarted", {24'd0, f_tmr()}, 32'd2);
        write_ctrl(8'd2, 8'd0, 3'b000);
        for (int i = 0; i < 3*P+2; i++) @(negedge clk);
        clear_flags(3'b111);
    endtask

    task automatic t_error();
        err_i = 1'b1;
        @(negedge clk);
        err_i = 1'b0;
        check("R8 error flag", {29'd0, f_flags()}, 32'b100);
        ctrl_ien_i = 3'b100;
        #1;
        check("R9 error irq", {31'd0, irq_o}, 32'd1);
        err_i = 1'b1;
        clear_flags(3'b100);
        err_i = 1'b0;
        check("R10 set wins over clear", {29'd0, f_flags()}, 32'b100);
        clear_flags(3'b100);
        check("R10 error cleared", {29'd0, f_flags()}, 32'd0);
        check("R11 reserved bits", {16'd0, stat_rdata_o[15], 3'd0, stat_rdata_o[11:0]}, 32'd0);
        ctrl_ien_i = 3'b000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_zero_thr();
        t_ctrl_override();
        t_delay();
        t_same_cycle();
        t_error();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule